// File: doc/BRIEF.md
# Raster Display Timing Generator

This block produces the raster timing for a display output: horizontal and vertical sync, a data-enable strobe, a blank flag, a black-forcing flag, and the pixel and line position inside the visible window. All timing is given as absolute positions counted from the start of the line or frame: where sync ends, where the active region starts and ends, and the total period. Software writes the values into a shadow register set through a simple write port.

Writes to the shadow set do not disturb the picture being scanned. A one-bit commit write arms a transfer. The whole shadow set is then copied to the active set at the last pixel of the current frame, so the next frame starts at position (0,0) with the new timing. The commit flag stays visible on `commitPending` until the copy happens. After reset the active set is all zero. With a zero period every cycle is a frame boundary, so the first commit takes effect one cycle after it is seen.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset `de`=0, `blank`=1, `blackOut`=0, `hsync`=1, `vsync`=1, `xPos`=`yPos`=0 and `commitPending`=0. The active set is all zero, so both syncs are active-low and idle.
- R2: Write addresses are as follows. 0 is commit (bit 0 = 1 arms a transfer). 1 is control. 2 is horizontal total, with sync end in bits 12:0 and period in bits 28:16. 3 is horizontal active, with active end in bits 12:0 and active start in bits 28:16. 4 and 5 are the vertical equivalents of 2 and 3, counted in lines. Control bit 4 sets hsync polarity, bit 5 sets vsync polarity, bit 18 forces blanking and bit 19 forces black.
- R3: The pixel counter runs from 0 to period-1. The line counter steps once per line and wraps after the vertical period.
- R4: Sync is active while the pixel counter (hsync) or the line counter (vsync) is below its sync end. Polarity bit = 1 makes the active level high; 0 makes it low.
- R5: `de` is 1 when the pixel counter lies in [active start, active end), the line counter lies in its window, and force-blank is clear. `blank` is the inverse of `de`.
- R6: `blackOut` is 1 inside the active window whenever force-black is set.
- R7: Inside the active window `xPos` and `yPos` equal the counters minus the active starts. Outside it they are 0.
- R8: Shadow writes have no effect on the outputs until a commit. A commit sets `commitPending`. The copy happens on the last cycle of a frame, the next cycle is position (0,0) under the new timing, and `commitPending` clears at the copy.
- R9: While the active period is zero, every cycle is a frame boundary, so a commit is applied on the cycle after it is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| de | output | 1 | Data enable |
| blank | output | 1 | Blank flag, inverse of de |
| blackOut | output | 1 | Force-black flag inside the active window |
| xPos | output | 13 | Pixel index inside the active window |
| yPos | output | 13 | Line index inside the active window |
| commitPending | output | 1 | Commit armed, copy not yet done |

## Verification
The outputs depend only on the counters and the active set, so they are valid in the same cycle as the counter value. A shadow write or commit seen at one edge changes `commitPending` at that edge. The active set changes only at the edge that ends a frame. The bench drives each stimulus at the falling edge. It steps its own counter model at the rising edge, then compares every output at the next falling edge, before the following stimulus. Because the model copies its own shadow values at the frame end it computes, mid-frame writes and commits are checked against the exact cycle where they should take effect.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;
  localparam int CNT_W = 13;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int HI_LSB = 16;

  localparam logic [ADDR_W-1:0] REG_COMMIT = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] REG_HTOT   = 3'd2;
  localparam logic [ADDR_W-1:0] REG_HACT   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_VTOT   = 3'd4;
  localparam logic [ADDR_W-1:0] REG_VACT   = 3'd5;

  localparam int BIT_HPOL  = 4;
  localparam int BIT_VPOL  = 5;
  localparam int BIT_BLANK = 18;
  localparam int BIT_BLACK = 19;

  typedef struct packed {
    logic [CNT_W-1:0] syncEnd;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] actStart;
    logic [CNT_W-1:0] actEnd;
  } axisTiming_t;

  typedef struct packed {
    axisTiming_t h;
    axisTiming_t v;
    logic hPolHigh;
    logic vPolHigh;
    logic forceBlank;
    logic forceBlack;
  } timing_t;

  typedef struct packed {
    logic copyNow;
  } ctlStrobe_t;
endpackage

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import raster_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameEnd,
  output ctlStrobe_t        strobe,
  output timing_t           shadow,
  output logic              commitPending
);
  logic commitWr;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;
  assign commitWr = wrEn && (wrAddr == REG_COMMIT) && wrData[0];
  assign strobe.copyNow = commitPending && frameEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitPending <= 1'b0;
    end else begin
      commitPending <= (commitPending && !strobe.copyNow) || commitWr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        REG_CTRL: begin
          shadow.hPolHigh   <= wrData[BIT_HPOL];
          shadow.vPolHigh   <= wrData[BIT_VPOL];
          shadow.forceBlank <= wrData[BIT_BLANK];
          shadow.forceBlack <= wrData[BIT_BLACK];
        end
        REG_HTOT: begin
          shadow.h.syncEnd <= wrData[CNT_W-1:0];
          shadow.h.total   <= wrData[HI_LSB+CNT_W-1:HI_LSB];
        end
        REG_HACT: begin
          shadow.h.actEnd   <= wrData[CNT_W-1:0];
          shadow.h.actStart <= wrData[HI_LSB+CNT_W-1:HI_LSB];
        end
        REG_VTOT: begin
          shadow.v.syncEnd <= wrData[CNT_W-1:0];
          shadow.v.total   <= wrData[HI_LSB+CNT_W-1:HI_LSB];
        end
        REG_VACT: begin
          shadow.v.actEnd   <= wrData[CNT_W-1:0];
          shadow.v.actStart <= wrData[HI_LSB+CNT_W-1:HI_LSB];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import raster_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  timing_t          shadow,
  output timing_t          act,
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt,
  output logic             lineEnd,
  output logic             frameEnd,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             blank,
  output logic             blackOut,
  output logic [CNT_W-1:0] xPos,
  output logic [CNT_W-1:0] yPos
);
  logic [CNT_W:0] hNext;
  logic [CNT_W:0] vNext;
  logic hInSync, vInSync, hInAct, vInAct, inWindow;

  assign hNext = {1'b0, hCnt} + 1'b1;
  assign vNext = {1'b0, vCnt} + 1'b1;
  assign lineEnd = hNext >= {1'b0, act.h.total};
  assign frameEnd = lineEnd && (vNext >= {1'b0, act.v.total});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      act  <= '0;
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      if (strobe.copyNow) act <= shadow;
      if (lineEnd) begin
        hCnt <= '0;
        vCnt <= frameEnd ? '0 : vNext[CNT_W-1:0];
      end else begin
        hCnt <= hNext[CNT_W-1:0];
      end
    end
  end

  assign hInSync = hCnt < act.h.syncEnd;
  assign vInSync = vCnt < act.v.syncEnd;
  assign hsync = act.hPolHigh ? hInSync : !hInSync;
  assign vsync = act.vPolHigh ? vInSync : !vInSync;

  assign hInAct = (hCnt >= act.h.actStart) && (hCnt < act.h.actEnd);
  assign vInAct = (vCnt >= act.v.actStart) && (vCnt < act.v.actEnd);
  assign inWindow = hInAct && vInAct;

  assign de = inWindow && !act.forceBlank;
  assign blank = !de;
  assign blackOut = inWindow && act.forceBlack;
  assign xPos = inWindow ? hCnt - act.h.actStart : '0;
  assign yPos = inWindow ? vCnt - act.v.actStart : '0;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              blank,
  output logic              blackOut,
  output logic [CNT_W-1:0]  xPos,
  output logic [CNT_W-1:0]  yPos,
  output logic              commitPending
);
  ctlStrobe_t strobe;
  timing_t shadow;
  timing_t act;
  logic [CNT_W-1:0] hCnt, vCnt;
  logic lineEnd, frameEnd;

  rtg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameEnd(frameEnd), .strobe(strobe), .shadow(shadow),
    .commitPending(commitPending)
  );

  rtg_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shadow(shadow), .act(act),
    .hCnt(hCnt), .vCnt(vCnt), .lineEnd(lineEnd), .frameEnd(frameEnd),
    .hsync(hsync), .vsync(vsync), .de(de), .blank(blank),
    .blackOut(blackOut), .xPos(xPos), .yPos(yPos)
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import raster_timing_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input timing_t           act,
  input logic [CNT_W-1:0]  hCnt,
  input logic [CNT_W-1:0]  vCnt,
  input logic              lineEnd,
  input logic              frameEnd,
  input logic              copyNow,
  input logic              de,
  input logic [CNT_W-1:0]  xPos,
  input logic              commitPending
);
  logic commitWr;
  assign commitWr = wrEn && (wrAddr == REG_COMMIT) && wrData[0];

  // R3: counters stay inside the programmed periods
  a_r3_h_range: assert property (@(posedge clk) disable iff (!rstN)
    (act.h.total != '0) |-> (hCnt < act.h.total));
  a_r3_v_range: assert property (@(posedge clk) disable iff (!rstN)
    (act.v.total != '0) |-> (vCnt < act.v.total));

  // R7: x position walks by one along an active line
  a_r7_x_walk: assert property (@(posedge clk) disable iff (!rstN)
    (de && $past(de) && !$past(lineEnd)) |-> (xPos == CNT_W'($past(xPos) + 1'b1)));

  // R8: active timing changes only on a copy
  a_r8_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !copyNow |=> $stable(act));

  // R8: pending commit clears at the frame boundary
  a_r8_pending_clear: assert property (@(posedge clk) disable iff (!rstN)
    (commitPending && frameEnd && !commitWr) |=> !commitPending);
endmodule

bind raster_timing_gen rtg_checker chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .act(act), .hCnt(hCnt), .vCnt(vCnt), .lineEnd(lineEnd),
  .frameEnd(frameEnd), .copyNow(strobe.copyNow), .de(de), .xPos(xPos),
  .commitPending(commitPending)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic hsync, vsync, de, blank, blackOut, commitPending;
  logic [12:0] xPos, yPos;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // bench model: active and shadow timing, counters, pending
  int cHS, cHT, cHAS, cHAE, cVS, cVT, cVAS, cVAE, cHP, cVP, cFB, cFK;
  int sHS, sHT, sHAS, sHAE, sVS, sVT, sVAS, sVAE, sHP, sVP, sFB, sFK;
  int mH, mV, mPend;

  always #2 clk = ~clk;

  raster_timing_gen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hsync(hsync), .vsync(vsync), .de(de), .blank(blank), .blackOut(blackOut),
    .xPos(xPos), .yPos(yPos), .commitPending(commitPending)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int actv, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (h=%0d v=%0d)",
               req, what, actv, expv, mH, mV);
    end
  endtask

  function automatic bit inWin();
    return (mH >= cHAS) && (mH < cHAE) && (mV >= cVAS) && (mV < cVAE);
  endfunction

  function automatic int expSync(int cnt, int syncEnd, int pol);
    bit s = cnt < syncEnd;
    return pol != 0 ? int'(s) : int'(!s);
  endfunction

  task automatic compareAll();
    int eDe = (inWin() && cFB == 0) ? 1 : 0;
    int eX = inWin() ? mH - cHAS : 0;
    int eY = inWin() ? mV - cVAS : 0;
    int eBk = (inWin() && cFK != 0) ? 1 : 0;
    chk(int'(hsync) == expSync(mH, cHS, cHP), "R4", "hsync", hsync, expSync(mH, cHS, cHP));
    chk(int'(vsync) == expSync(mV, cVS, cVP), "R4", "vsync", vsync, expSync(mV, cVS, cVP));
    chk(int'(de) == eDe, "R3 R5", "de", de, eDe);
    chk(int'(blank) == 1 - eDe, "R5", "blank", blank, 1 - eDe);
    chk(int'(blackOut) == eBk, "R6", "blackOut", blackOut, eBk);
    chk(int'(xPos) == eX, "R7", "xPos", xPos, eX);
    chk(int'(yPos) == eY, "R7", "yPos", yPos, eY);
    chk(int'(commitPending) == mPend, "R8", "commitPending", commitPending, mPend);
  endtask

  // one cycle: compare at the falling edge, drive, model the rising edge
  task automatic step(input bit wen, input int addr, input int data);
    bit lineEnd, frameEnd, copy;
    compareAll();
    wrEn = wen; wrAddr = addr[2:0]; wrData = data;
    @(posedge clk);
    lineEnd = (mH + 1) >= cHT;
    frameEnd = lineEnd && ((mV + 1) >= cVT);
    copy = frameEnd && (mPend != 0);
    if (copy) begin
      cHS = sHS; cHT = sHT; cHAS = sHAS; cHAE = sHAE;
      cVS = sVS; cVT = sVT; cVAS = sVAS; cVAE = sVAE;
      cHP = sHP; cVP = sVP; cFB = sFB; cFK = sFK;
    end
    if (lineEnd) begin
      mH = 0;
      mV = frameEnd ? 0 : mV + 1;
    end else mH = mH + 1;
    mPend = ((mPend != 0 && !copy) || (wen && addr == 0 && data[0])) ? 1 : 0;
    if (wen) begin
      case (addr)
        1: begin sHP = data[4]; sVP = data[5]; sFB = data[18]; sFK = data[19]; end
        2: begin sHS = data & 'h1fff; sHT = (data >> 16) & 'h1fff; end
        3: begin sHAE = data & 'h1fff; sHAS = (data >> 16) & 'h1fff; end
        4: begin sVS = data & 'h1fff; sVT = (data >> 16) & 'h1fff; end
        5: begin sVAE = data & 'h1fff; sVAS = (data >> 16) & 'h1fff; end
        default: ;
      endcase
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  // R2: field packing of the timing words
  task automatic writeMode(input int hs, input int hbp, input int ha, input int hfp,
                           input int vs, input int vbp, input int va, input int vfp,
                           input int hp, input int vp, input int fb, input int fk);
    step(1, 1, (hp << 4) | (vp << 5) | (fb << 18) | (fk << 19));
    step(1, 2, ((hs + hbp + ha + hfp) << 16) | hs);
    step(1, 3, ((hs + hbp) << 16) | (hs + hbp + ha));
    step(1, 4, ((vs + vbp + va + vfp) << 16) | vs);
    step(1, 5, ((vs + vbp) << 16) | (vs + vbp + va));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h1f2e3d);
    {cHS, cHT, cHAS, cHAE, cVS, cVT, cVAS, cVAE, cHP, cVP, cFB, cFK} = '0;
    {sHS, sHT, sHAS, sHAE, sVS, sVT, sVAS, sVAE, sHP, sVP, sFB, sFK} = '0;
    mH = 0; mV = 0; mPend = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(de == 1'b0, "R1", "de", de, 0);
    chk(blank == 1'b1, "R1", "blank", blank, 1);
    chk(hsync == 1'b1 && vsync == 1'b1, "R1", "syncs", {hsync, vsync}, 3);
    chk(xPos == 0 && yPos == 0 && blackOut == 0, "R1", "pos/black", xPos + yPos + blackOut, 0);
    chk(commitPending == 1'b0, "R1", "commitPending", commitPending, 0);

    // directed mode: 8x4 active, high polarity
    writeMode(2, 3, 8, 2, 1, 2, 4, 1, 1, 1, 0, 0);
    idle(5);
    chk(de == 1'b0, "R8", "de before commit", de, 0);
    step(1, 0, 1);
    chk(commitPending == 1'b1, "R2", "pending after commit", commitPending, 1);
    step(0, 0, 0);
    chk(commitPending == 1'b0, "R9", "pending after zero-period copy", commitPending, 0);
    idle(15 * 8 * 3);

    // mid-frame shadow write without commit, then a mid-frame commit
    idle(40);
    writeMode(1, 1, 5, 1, 2, 1, 3, 2, 0, 0, 0, 1);
    idle(200);
    step(1, 0, 1);
    idle(300);

    // forced blanking and black
    writeMode(3, 1, 6, 2, 1, 1, 3, 1, 1, 0, 1, 1);
    step(1, 0, 1);
    idle(12 * 6 * 2 + 80);

    // random modes
    for (int k = 0; k < 10; k++) begin
      writeMode(1 + $urandom_range(2), $urandom_range(3), 1 + $urandom_range(9),
                $urandom_range(3), 1 + $urandom_range(1), $urandom_range(2),
                1 + $urandom_range(4), $urandom_range(2), $urandom_range(1),
                $urandom_range(1), ($urandom_range(3) == 0) ? 1 : 0, $urandom_range(1));
      step(1, 0, 1);
      idle(600 + $urandom_range(50));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule